// File: doc/BRIEF.md
# Backplane Slot Request Arbiter

This block sits on the bus-master card of a multi-slot backplane and decides which plug-in card may drive the shared half-duplex serial transmit pair. Each slot has an active-low request line, a presence-detect input and an active-low select line. The arbiter synchronizes the request and presence inputs, masks out empty slots and grants one requesting card at a time by pulling its select line low.

A grant lasts until the bus-master logic pulses a transfer-done input, until a timeout counter expires, or until the granted card disappears from its slot. After a grant ends, every select line is held high for at least one full cycle. The next winner is then chosen round-robin, starting from the slot after the one that last held the bus. A valid flag and the binary slot index go back to the bus-master logic, so that it knows which card owns the bus.

Top module: `slot_arbiter`

## Requirements
- R1: A slot is eligible when its `req_n` bit is 0 (requesting) and its `present_n` bit is 0 (card fitted). Both inputs pass through a SYNC_STAGES-flop synchronizer. With SYNC_STAGES=2 and an idle arbiter, the select of a newly requesting slot goes low after the third rising edge following the input change.
- R2: `sel_n` is active low, and at most one bit of `sel_n` is 0 at any time.
- R3: `grant_valid` is 1 exactly while one select is low, and `grant_idx` then holds the binary index of that slot.
- R4: A slot whose synchronized `present_n` is 1 is never granted, even while it requests.
- R5: When several slots are eligible, the winner is the first eligible slot found by searching upward, with wrap-around, from the slot after the last granted one.
- R6: If `xfer_done` is 1 at a rising edge while a grant is held, the grant ends at that edge, and all selects are high in the following cycle.
- R7: A select stays low for at most TIMEOUT_CYCLES cycles. Without `xfer_done` it is released after exactly TIMEOUT_CYCLES cycles.
- R8: Between two grants there is at least one cycle in which all of `sel_n` is high. A grant never switches directly from one slot to another.
- R9: After reset, `sel_n` is all ones, `grant_valid` is 0, `grant_idx` is 0 and the round-robin search starts at slot 0.
- R10: If the granted slot's `present_n` goes to 1, the grant ends after the third rising edge following that change (SYNC_STAGES=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_SLOTS | Per-slot request, active low, asynchronous |
| present_n | input | NUM_SLOTS | Per-slot presence detect, 0 = card fitted, asynchronous |
| xfer_done | input | 1 | One-cycle pulse from bus-master logic ending the current transfer |
| sel_n | output | NUM_SLOTS | Per-slot select, active low, permits driving the shared pair |
| grant_valid | output | 1 | A slot currently owns the bus |
| grant_idx | output | IDX_W | Binary index of the owning slot |

## Verification
The bench builds the arbiter with four slots, a two-stage synchronizer and a timeout of only eight cycles. The short timeout lets an expiry be observed and measured to the exact cycle. Four slots are enough to show the round-robin order wrapping from the last slot back to slot 0, the search skipping a slot that is not requesting, and an empty slot being passed over while it still requests. The two-stage synchronizer fixes the grant and presence-loss latencies, so the bench can check them at exact edges.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_OWN  = 2'd1,
      ARB_GAP  = 2'd2
   } arb_state_e;

   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
   parameter int               WIDTH     = 4,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("slot_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
            end else begin
               chain[0] <= d;
               for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  cand,
   input  logic [IW-1:0] start,
   output logic          hit,
   output logic [IW-1:0] win
);

   always_comb begin
      int j;
      hit = 1'b0;
      win = '0;
      j   = 0;
      for (int k = 0; k < N; k++) begin
         j = (int'(start) + k) % N;
         if (!hit && cand[j]) begin
            hit = 1'b1;
            win = IW'(j);
         end
      end
   end

endmodule

// File: rtl/grant_timer.sv
module grant_timer #(
   parameter int LIMIT = 1024,
   parameter int W     = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("grant_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clear)            cnt <= '0;
      else if (run && !expired)  cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
   parameter int NUM_SLOTS      = 4,
   parameter int TIMEOUT_CYCLES = 1024,
   parameter int SYNC_STAGES    = 2,
   localparam int IDX_W         = slot_arb_pkg::idx_width(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] req_n,
   input  logic [NUM_SLOTS-1:0] present_n,
   input  logic                 xfer_done,
   output logic [NUM_SLOTS-1:0] sel_n,
   output logic                 grant_valid,
   output logic [IDX_W-1:0]     grant_idx
);
   import slot_arb_pkg::*;

   localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("slot_arbiter: NUM_SLOTS must be at least 2");
      end
      if (TIMEOUT_CYCLES < 1) begin : g_bad_timeout
         $error("slot_arbiter: TIMEOUT_CYCLES must be at least 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] req_s_n;
   logic [NUM_SLOTS-1:0] pres_s_n;
   logic [NUM_SLOTS-1:0] eligible;
   logic                 pick_hit;
   logic [IDX_W-1:0]     pick_idx;
   logic [IDX_W-1:0]     rr_ptr;
   logic [IDX_W-1:0]     owner_idx;
   logic [IDX_W-1:0]     next_ptr;
   logic                 owner_present;
   logic                 tmr_clear;
   logic                 tmr_run;
   logic                 tmr_expired;
   logic                 release_now;
   arb_state_e           state;

   slot_sync #(.WIDTH(NUM_SLOTS), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s_n)
   );

   slot_sync #(.WIDTH(NUM_SLOTS), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_pres_sync (
      .clk(clk), .rst_n(rst_n), .d(present_n), .q(pres_s_n)
   );

   assign eligible = ~req_s_n & ~pres_s_n;

   rr_pick #(.N(NUM_SLOTS), .IW(IDX_W)) u_pick (
      .cand(eligible), .start(rr_ptr), .hit(pick_hit), .win(pick_idx)
   );

   assign tmr_clear = (state == ARB_IDLE) && pick_hit;
   assign tmr_run   = (state == ARB_OWN);

   grant_timer #(.LIMIT(TIMEOUT_CYCLES), .W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run), .expired(tmr_expired)
   );

   assign owner_present = ~pres_s_n[owner_idx];
   assign release_now   = (state == ARB_OWN) && (xfer_done || tmr_expired || !owner_present);
   assign next_ptr      = (owner_idx == IDX_W'(NUM_SLOTS - 1)) ? '0 : owner_idx + 1'b1;

   function automatic logic [NUM_SLOTS-1:0] select_pattern(input logic [IDX_W-1:0] idx);
      logic [NUM_SLOTS-1:0] pat;
      pat = '1;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (IDX_W'(s) == idx) pat[s] = 1'b0;
      return pat;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ARB_IDLE;
         owner_idx   <= '0;
         rr_ptr      <= '0;
         sel_n       <= '1;
         grant_valid <= 1'b0;
      end else begin
         case (state)
            ARB_IDLE: begin
               if (pick_hit) begin
                  state       <= ARB_OWN;
                  owner_idx   <= pick_idx;
                  sel_n       <= select_pattern(pick_idx);
                  grant_valid <= 1'b1;
               end
            end
            ARB_OWN: begin
               if (release_now) begin
                  state       <= ARB_GAP;
                  sel_n       <= '1;
                  grant_valid <= 1'b0;
                  rr_ptr      <= next_ptr;
               end
            end
            default: begin
               state <= ARB_IDLE;
            end
         endcase
      end
   end

   assign grant_idx = owner_idx;

endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
   parameter int N  = 4,
   parameter int T  = 1024,
   parameter int IW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  sel_n,
   input logic          grant_valid,
   input logic [IW-1:0] grant_idx,
   input logic          xfer_done,
   input logic [N-1:0]  pres_s_n
);

   localparam int CW = $clog2(T + 2) + 1;

   logic [CW-1:0] hold_cnt;
   logic [N-1:0]  pres_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         pres_q   <= '1;
      end else begin
         pres_q   <= pres_s_n;
         hold_cnt <= grant_valid ? hold_cnt + 1'b1 : '0;
      end
   end

   a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n));

   a_r3_idx_selects: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> !sel_n[grant_idx]);

   a_r3_idle_all_high: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> (&sel_n));

   a_r4_present_at_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_valid) |-> !pres_q[grant_idx]);

   a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && grant_valid) |=> !grant_valid);

   a_r7_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt <= CW'(T));

   a_r8_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(grant_valid)) |-> ($stable(grant_idx) && $stable(sel_n)));

endmodule

bind slot_arbiter slot_arbiter_chk #(.N(NUM_SLOTS), .T(TIMEOUT_CYCLES), .IW(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .grant_valid(grant_valid),
   .grant_idx(grant_idx), .xfer_done(xfer_done), .pres_s_n(pres_s_n)
);

// File: tb/slot_arbiter_test.sv
`timescale 1ns/1ps
module slot_arbiter_test;

   localparam int N  = 4;
   localparam int T  = 8;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_n = '1;
   logic [N-1:0]  present_n = '0;
   logic          xfer_done = 1'b0;
   logic [N-1:0]  sel_n;
   logic          grant_valid;
   logic [IW-1:0] grant_idx;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  mon_on   = 1'b0;
   bit  prev_valid = 1'b0;
   logic [IW-1:0] prev_idx = '0;
   int  run_len  = 0;

   always #2.5 clk = ~clk;

   slot_arbiter #(.NUM_SLOTS(N), .TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .present_n(present_n),
      .xfer_done(xfer_done), .sel_n(sel_n), .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] expect_sel(input int idx);
      logic [N-1:0] p;
      p = '1;
      p[idx] = 1'b0;
      return p;
   endfunction

   // continuous port-level monitor for R2, R3, R7, R8
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         check($countones(~sel_n) <= 1, "R2", "selects low", $countones(~sel_n), 1);
         if (grant_valid)
            check(sel_n == expect_sel(int'(grant_idx)), "R3", "sel_n vs idx",
                  int'(sel_n), int'(expect_sel(int'(grant_idx))));
         else
            check(&sel_n, "R3", "sel_n while not valid", int'(sel_n), int'({N{1'b1}}));
         if (prev_valid && grant_valid)
            check(grant_idx == prev_idx, "R8", "direct switch idx", int'(grant_idx), int'(prev_idx));
         run_len = grant_valid ? run_len + 1 : 0;
         check(run_len <= T, "R7", "hold length", run_len, T);
         prev_valid = grant_valid;
         prev_idx   = grant_idx;
      end
   end

   task automatic pulse_done();
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic wait_grant(input int maxc, output bit got);
      got = 1'b0;
      for (int i = 0; i < maxc && !got; i++) begin
         @(negedge clk);
         if (grant_valid) got = 1'b1;
      end
   endtask

   task automatic settle();
      req_n = '1;
      repeat (4) @(negedge clk);
      pulse_done();
      repeat (4) @(negedge clk);
      check(!grant_valid, "R6", "idle after settle", grant_valid, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(sel_n == '1, "R9", "sel_n in reset", int'(sel_n), int'({N{1'b1}}));
      check(!grant_valid, "R9", "valid in reset", grant_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      check(grant_idx == 0, "R9", "idx after reset", int'(grant_idx), 0);
      check(sel_n == '1, "R9", "sel_n after reset", int'(sel_n), int'({N{1'b1}}));
   endtask

   task automatic t_round_robin();
      bit got;
      int order[5] = '{0, 1, 2, 3, 0};
      present_n = '0;
      req_n = '0;
      @(negedge clk);
      @(negedge clk);
      check(!grant_valid, "R1", "no grant after two edges", grant_valid, 0);
      @(negedge clk);
      check(grant_valid, "R1", "grant after third edge", grant_valid, 1);
      check(grant_idx == 0, "R9", "first winner from pointer 0", int'(grant_idx), 0);
      for (int k = 1; k < 5; k++) begin
         pulse_done();
         check(!grant_valid, "R6", "released after done", grant_valid, 0);
         wait_grant(8, got);
         check(got && grant_idx == IW'(order[k]), "R5", "round-robin order",
               int'(grant_idx), order[k]);
      end
      settle();
   endtask

   task automatic t_absent();
      bit got;
      present_n = 4'b0010;
      req_n     = 4'b0101;
      wait_grant(8, got);
      check(got && grant_idx == 3, "R4", "absent slot 1 skipped", int'(grant_idx), 3);
      req_n[3] = 1'b1;
      pulse_done();
      got = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (grant_valid) got = 1'b1;
      end
      check(!got, "R4", "absent slot 1 never granted", got, 0);
      settle();
      present_n = '0;
   endtask

   task automatic t_timeout();
      bit got;
      int len;
      req_n = 4'b1011;
      wait_grant(8, got);
      check(got && grant_idx == 2, "R7", "timeout slot granted", int'(grant_idx), 2);
      len = 1;
      for (int i = 0; i < 3 * T && grant_valid; i++) begin
         @(negedge clk);
         if (grant_valid) len++;
      end
      check(len == T, "R7", "expiry length", len, T);
      settle();
   endtask

   task automatic t_presence_loss();
      bit got;
      req_n = 4'b1110;
      wait_grant(8, got);
      check(got && grant_idx == 0, "R10", "slot 0 granted", int'(grant_idx), 0);
      present_n[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(grant_valid, "R10", "held two edges after removal", grant_valid, 1);
      @(negedge clk);
      check(!grant_valid, "R10", "released at third edge", grant_valid, 0);
      got = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (grant_valid) got = 1'b1;
      end
      check(!got, "R4", "removed slot not regranted", got, 0);
      settle();
      present_n = '0;
   endtask

   task automatic t_sparse();
      bit got;
      // pointer is now at slot 1; slots 0 and 2 request
      req_n = 4'b1010;
      wait_grant(8, got);
      check(got && grant_idx == 2, "R5", "search skips idle slot 1", int'(grant_idx), 2);
      pulse_done();
      @(negedge clk);
      check(!grant_valid && sel_n == '1, "R8", "gap cycle all high", int'(sel_n), int'({N{1'b1}}));
      wait_grant(8, got);
      check(got && grant_idx == 0, "R5", "wrap to slot 0", int'(grant_idx), 0);
      settle();
   endtask

   initial begin
      t_reset();
      t_round_robin();
      t_absent();
      t_timeout();
      t_presence_loss();
      t_sparse();
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #50000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule